// File: doc/BRIEF.md
# Processor Status Word Flag Unit

This block holds the eight-bit status word of a small eight-bit CPU and decides, every clock, what each flag becomes. The execution pipeline sends it result information from the ALU: the eight-bit result, the carry or borrow, a half-carry indication and a signed-overflow indication. It also sends single-cycle strobes for the dedicated flag instructions, a bit-test strobe with its memory operand, an interrupt-accept pulse and a full-word restore used when the word is popped back from the stack.

The block drives the status word itself, the master interrupt enable, and the direct-page select bit together with the base address that selects the direct page. The ALU and the interrupt controller sit outside this block. Each flag changes only when a strobe or enable that targets it is active, so the CPU sequencer can update any subset of flags in a single cycle.

Top module: `psw_flag_unit`

## Requirements
- R1: A synchronous active-low reset clears the whole word to 0x00, so `int_en`, `page_sel` and `dp_base` are all zero on the cycle after reset.
- R2: The word layout, from bit 7 down to bit 0, is N, V, G, B, H, I, Z, C. When `restore_en` is high, `restore_word` is loaded into all eight bits on the next edge and every other update in that cycle is ignored.
- R3: When `upd_nz` is high, Z becomes 1 if `alu_res` is 0x00 and 0 otherwise, and N becomes `alu_res[7]`.
- R4: When `upd_v` is high, V takes the value of `alu_ovf`.
- R5: When `upd_h` is high, H takes the value of `alu_half`. The ALU provides the carry out of bit 3 for additions and the inverted borrow from bit 4 for subtractions.
- R6: When `upd_c` is high, C takes `alu_carry` if `c_from_shift` is 0 and `shift_bit` if it is 1.
- R7: `flag_cmd` = 1 (overflow clear) clears both V and H. It overrides every other source of V and H in the same cycle. No command sets V directly.
- R8: When `bit_test` is high, N takes `mem_opnd[7]` and V takes `mem_opnd[6]`. This overrides the ALU values for N and V. No other bit changes unless its own enable is active.
- R9: `flag_cmd` = 2 sets I and `flag_cmd` = 3 clears I. `int_en` always equals bit 2 of the word.
- R10: When `int_accept` is high, I is 0 after the next edge, even if an interrupt-enable command arrives in the same cycle.
- R11: `flag_cmd` = 4 sets G and `flag_cmd` = 5 clears G. `dp_base` is 0x0000 when G is 0 and 0x0100 when G is 1.
- R12: `flag_cmd` = 6 (software break) sets B. B then stays set through ALU updates and other commands until a restore or a reset.
- R13: A flag whose enable, strobe and commands are all inactive keeps its value, whatever the ALU inputs carry. `flag_cmd` = 0 is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alu_res | input | 8 | ALU result |
| alu_carry | input | 1 | ALU carry out or borrow |
| alu_half | input | 1 | ALU half-carry indication |
| alu_ovf | input | 1 | ALU signed overflow |
| shift_bit | input | 1 | Bit shifted out by a shift or rotate |
| upd_nz | input | 1 | Update N and Z from the result |
| upd_c | input | 1 | Update C |
| upd_h | input | 1 | Update H |
| upd_v | input | 1 | Update V |
| c_from_shift | input | 1 | C source select: 0 ALU carry, 1 shifted-out bit |
| flag_cmd | input | 3 | Dedicated flag command (0 none, 1 clear V/H, 2 set I, 3 clear I, 4 set G, 5 clear G, 6 break) |
| bit_test | input | 1 | Bit-test strobe |
| mem_opnd | input | 8 | Memory operand for the bit test |
| int_accept | input | 1 | Interrupt accepted pulse |
| restore_en | input | 1 | Load the whole word |
| restore_word | input | 8 | Word to load |
| psw | output | 8 | Status word |
| int_en | output | 1 | Master interrupt enable (I) |
| page_sel | output | 1 | Direct-page select (G) |
| dp_base | output | 16 | Direct-page base address |

## Verification
The bench first loads a known starting word with a restore, then applies one update cycle and compares the whole word. This shows which bits moved and also that every other bit stayed put. The zero flag is driven with a zero result and with non-zero results, both with and without bit 7 set, so the N and Z paths are told apart. The carry is driven with the ALU carry and the shift bit set to opposite values under both select settings, which exposes an inverted or ignored select. The same-cycle conflicts are tried one by one: overflow clear against ALU updates, bit test against the ALU and against overflow clear, interrupt accept against enable, and restore against everything. Each of these shows that the priority chain is in the stated order.

// File: rtl/psw_pkg.sv
// Shared definitions for the status word unit: bit positions and the
// dedicated flag command encoding. Bit positions are fixed because the
// stack restore path and software read the word as a whole.
package psw_pkg;
    localparam int PSW_W   = 8;
    localparam int POS_C   = 0;
    localparam int POS_Z   = 1;
    localparam int POS_I   = 2;
    localparam int POS_H   = 3;
    localparam int POS_B   = 4;
    localparam int POS_G   = 5;
    localparam int POS_V   = 6;
    localparam int POS_N   = 7;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_OVF_CLR = 3'd1,
        CMD_IRQ_ON  = 3'd2,
        CMD_IRQ_OFF = 3'd3,
        CMD_PAGE_HI = 3'd4,
        CMD_PAGE_LO = 3'd5,
        CMD_BREAK   = 3'd6
    } psw_cmd_e;
endpackage

// File: rtl/psw_arith_flags.sv
// Next-state logic for the arithmetic flags N, Z, C, H and V.
// Assumes: the ALU hands over an already-formed half-carry and overflow
// indication; priority per flag is overflow-clear > bit test > ALU > hold.
module psw_arith_flags #(
    parameter int DATA_W = 8
) (
    input  logic              cur_n,
    input  logic              cur_z,
    input  logic              cur_c,
    input  logic              cur_h,
    input  logic              cur_v,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_carry,
    input  logic              alu_half,
    input  logic              alu_ovf,
    input  logic              shift_bit,
    input  logic              upd_nz,
    input  logic              upd_c,
    input  logic              upd_h,
    input  logic              upd_v,
    input  logic              c_from_shift,
    input  logic              clr_vh,
    input  logic              bit_test,
    input  logic              opnd_msb,
    input  logic              opnd_msb1,
    output logic              nxt_n,
    output logic              nxt_z,
    output logic              nxt_c,
    output logic              nxt_h,
    output logic              nxt_v
);
    localparam int MSB = DATA_W - 1;

    // Sign and zero: bit test owns N, ALU owns both otherwise.
    always_comb begin
        nxt_n = cur_n;
        nxt_z = cur_z;
        if (upd_nz) begin
            nxt_n = alu_res[MSB];
            nxt_z = (alu_res == '0);
        end
        if (bit_test) begin
            nxt_n = opnd_msb;
        end
    end

    // Carry: source chosen between ALU carry and the shifted-out bit.
    always_comb begin
        nxt_c = cur_c;
        if (upd_c) begin
            nxt_c = c_from_shift ? shift_bit : alu_carry;
        end
    end

    // Half carry and overflow: the clear command wins over every source.
    always_comb begin
        nxt_h = cur_h;
        nxt_v = cur_v;
        if (upd_h) begin
            nxt_h = alu_half;
        end
        if (upd_v) begin
            nxt_v = alu_ovf;
        end
        if (bit_test) begin
            nxt_v = opnd_msb1;
        end
        if (clr_vh) begin
            nxt_h = 1'b0;
            nxt_v = 1'b0;
        end
    end
endmodule

// File: rtl/psw_ctrl_flags.sv
// Next-state logic for the control flags: interrupt enable I, page select G
// and break B. Assumes one command per cycle; interrupt accept beats an
// interrupt-enable command in the same cycle. B is only cleared by reset
// or restore, both handled by the caller.
module psw_ctrl_flags
    import psw_pkg::*;
(
    input  logic     cur_i,
    input  logic     cur_g,
    input  logic     cur_b,
    input  psw_cmd_e cmd,
    input  logic     int_accept,
    output logic     nxt_i,
    output logic     nxt_g,
    output logic     nxt_b
);
    // Decode the command into the flag it targets.
    always_comb begin
        nxt_i = cur_i;
        nxt_g = cur_g;
        nxt_b = cur_b;
        unique case (cmd)
            CMD_IRQ_ON:  nxt_i = 1'b1;
            CMD_IRQ_OFF: nxt_i = 1'b0;
            CMD_PAGE_HI: nxt_g = 1'b1;
            CMD_PAGE_LO: nxt_g = 1'b0;
            CMD_BREAK:   nxt_b = 1'b1;
            default:     ;
        endcase
        if (int_accept) begin
            nxt_i = 1'b0;
        end
    end
endmodule

// File: rtl/psw_page_map.sv
// Maps the page select bit to the base address of the direct page.
// Assumes pages are 2**PAGE_SHIFT bytes and only pages 0 and 1 exist.
module psw_page_map #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_SHIFT = 8
) (
    input  logic              page_sel,
    output logic [ADDR_W-1:0] base
);
    localparam logic [ADDR_W-1:0] PAGE1_BASE = ADDR_W'(1) << PAGE_SHIFT;

    // Select the base of page 0 or page 1.
    always_comb begin
        base = page_sel ? PAGE1_BASE : '0;
    end
endmodule

// File: rtl/psw_flag_unit.sv
// Status word register of an 8-bit CPU. Merges the arithmetic and control
// flag next-state logic into one word, applies the whole-word restore with
// top priority and registers the result. Synchronous active-low reset.
module psw_flag_unit
    import psw_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        alu_res,
    input  logic              alu_carry,
    input  logic              alu_half,
    input  logic              alu_ovf,
    input  logic              shift_bit,
    input  logic              upd_nz,
    input  logic              upd_c,
    input  logic              upd_h,
    input  logic              upd_v,
    input  logic              c_from_shift,
    input  logic [2:0]        flag_cmd,
    input  logic              bit_test,
    input  logic [7:0]        mem_opnd,
    input  logic              int_accept,
    input  logic              restore_en,
    input  logic [7:0]        restore_word,
    output logic [7:0]        psw,
    output logic              int_en,
    output logic              page_sel,
    output logic [ADDR_W-1:0] dp_base
);
    psw_cmd_e          cmd;
    logic [PSW_W-1:0]  psw_q;
    logic [PSW_W-1:0]  upd_word;
    logic              clr_vh;
    logic              n_n, n_z, n_c, n_h, n_v, n_i, n_g, n_b;

    // Command decode shared by both flag groups.
    always_comb begin
        cmd    = psw_cmd_e'(flag_cmd);
        clr_vh = (cmd == CMD_OVF_CLR);
    end

    psw_arith_flags #(.DATA_W(PSW_W)) u_arith (
        .cur_n        (psw_q[POS_N]),
        .cur_z        (psw_q[POS_Z]),
        .cur_c        (psw_q[POS_C]),
        .cur_h        (psw_q[POS_H]),
        .cur_v        (psw_q[POS_V]),
        .alu_res      (alu_res),
        .alu_carry    (alu_carry),
        .alu_half     (alu_half),
        .alu_ovf      (alu_ovf),
        .shift_bit    (shift_bit),
        .upd_nz       (upd_nz),
        .upd_c        (upd_c),
        .upd_h        (upd_h),
        .upd_v        (upd_v),
        .c_from_shift (c_from_shift),
        .clr_vh       (clr_vh),
        .bit_test     (bit_test),
        .opnd_msb     (mem_opnd[7]),
        .opnd_msb1    (mem_opnd[6]),
        .nxt_n        (n_n),
        .nxt_z        (n_z),
        .nxt_c        (n_c),
        .nxt_h        (n_h),
        .nxt_v        (n_v)
    );

    psw_ctrl_flags u_ctrl (
        .cur_i      (psw_q[POS_I]),
        .cur_g      (psw_q[POS_G]),
        .cur_b      (psw_q[POS_B]),
        .cmd        (cmd),
        .int_accept (int_accept),
        .nxt_i      (n_i),
        .nxt_g      (n_g),
        .nxt_b      (n_b)
    );

    // Assemble the per-flag results into the fixed word layout.
    always_comb begin
        upd_word        = '0;
        upd_word[POS_N] = n_n;
        upd_word[POS_V] = n_v;
        upd_word[POS_G] = n_g;
        upd_word[POS_B] = n_b;
        upd_word[POS_H] = n_h;
        upd_word[POS_I] = n_i;
        upd_word[POS_Z] = n_z;
        upd_word[POS_C] = n_c;
    end

    // Status register: reset, then restore, then individual updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psw_q <= '0;
        end else if (restore_en) begin
            psw_q <= restore_word;
        end else begin
            psw_q <= upd_word;
        end
    end

    psw_page_map #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_page (
        .page_sel (psw_q[POS_G]),
        .base     (dp_base)
    );

    // Drive the word and its dedicated bit outputs.
    always_comb begin
        psw      = psw_q;
        int_en   = psw_q[POS_I];
        page_sel = psw_q[POS_G];
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (psw == 8'h00));

    p_restore_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> (psw == $past(restore_word)));

    p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && flag_cmd == 3'd1) |=> (!psw[POS_V] && !psw[POS_H]));

    p_bit_test_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && bit_test && flag_cmd != 3'd1)
        |=> (psw[POS_N] == $past(mem_opnd[7]) && psw[POS_V] == $past(mem_opnd[6])));

    p_irq_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && int_accept) |=> !int_en);

    p_break_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && flag_cmd == 3'd6) |=> psw[POS_B]);

    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && !upd_nz && !upd_c && !upd_h && !upd_v && !bit_test
         && !int_accept && flag_cmd == 3'd0) |=> $stable(psw));
endmodule

// File: tb/psw_flag_unit_test.sv
module psw_flag_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 5000;
    localparam int NV         = 25;

    // Vector: req, start word, result, {carry,half,ovf,shift},
    // {nz,c,h,v,csel}, cmd, bit_test, mem, accept, expected word.
    localparam logic [49:0] TBL [NV] = '{
        {4'd3,  8'h00, 8'h00, 4'b0000, 5'b10000, 3'd0, 1'b0, 8'h00, 1'b0, 8'h02}, // R3 zero
        {4'd3,  8'h02, 8'h80, 4'b0000, 5'b10000, 3'd0, 1'b0, 8'h00, 1'b0, 8'h80}, // R3 negative
        {4'd3,  8'h83, 8'h35, 4'b0000, 5'b10000, 3'd0, 1'b0, 8'h00, 1'b0, 8'h01}, // R3 positive
        {4'd4,  8'h00, 8'h00, 4'b0010, 5'b00010, 3'd0, 1'b0, 8'h00, 1'b0, 8'h40}, // R4 set
        {4'd4,  8'h40, 8'h00, 4'b0000, 5'b00010, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00}, // R4 clear
        {4'd5,  8'h00, 8'h00, 4'b0100, 5'b00100, 3'd0, 1'b0, 8'h00, 1'b0, 8'h08}, // R5 set
        {4'd5,  8'h08, 8'h00, 4'b0000, 5'b00100, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00}, // R5 clear
        {4'd6,  8'h00, 8'h00, 4'b1000, 5'b01000, 3'd0, 1'b0, 8'h00, 1'b0, 8'h01}, // R6 alu carry
        {4'd6,  8'h01, 8'h00, 4'b1000, 5'b01001, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00}, // R6 shift 0
        {4'd6,  8'h00, 8'h00, 4'b0001, 5'b01001, 3'd0, 1'b0, 8'h00, 1'b0, 8'h01}, // R6 shift 1
        {4'd6,  8'h01, 8'h00, 4'b0001, 5'b01000, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00}, // R6 carry 0
        {4'd7,  8'hFF, 8'h00, 4'b0110, 5'b00110, 3'd1, 1'b0, 8'h00, 1'b0, 8'hB7}, // R7 beats alu
        {4'd7,  8'h00, 8'h00, 4'b0000, 5'b00000, 3'd1, 1'b1, 8'hC0, 1'b0, 8'h80}, // R7 beats test
        {4'd8,  8'h00, 8'h00, 4'b0000, 5'b00000, 3'd0, 1'b1, 8'hC0, 1'b0, 8'hC0}, // R8 copy 1s
        {4'd8,  8'hC0, 8'h00, 4'b0000, 5'b00000, 3'd0, 1'b1, 8'h3F, 1'b0, 8'h00}, // R8 copy 0s
        {4'd8,  8'h00, 8'h41, 4'b0010, 5'b10010, 3'd0, 1'b1, 8'h80, 1'b0, 8'h80}, // R8 beats alu
        {4'd9,  8'h00, 8'h00, 4'b0000, 5'b00000, 3'd2, 1'b0, 8'h00, 1'b0, 8'h04}, // R9 enable
        {4'd9,  8'hFF, 8'h00, 4'b0000, 5'b00000, 3'd3, 1'b0, 8'h00, 1'b0, 8'hFB}, // R9 disable
        {4'd10, 8'h00, 8'h00, 4'b0000, 5'b00000, 3'd2, 1'b0, 8'h00, 1'b1, 8'h00}, // R10 vs enable
        {4'd10, 8'h04, 8'h00, 4'b0000, 5'b00000, 3'd0, 1'b0, 8'h00, 1'b1, 8'h00}, // R10 accept
        {4'd11, 8'h00, 8'h00, 4'b0000, 5'b00000, 3'd4, 1'b0, 8'h00, 1'b0, 8'h20}, // R11 page 1
        {4'd11, 8'hFF, 8'h00, 4'b0000, 5'b00000, 3'd5, 1'b0, 8'h00, 1'b0, 8'hDF}, // R11 page 0
        {4'd12, 8'h00, 8'h00, 4'b0000, 5'b00000, 3'd6, 1'b0, 8'h00, 1'b0, 8'h10}, // R12 break
        {4'd13, 8'h5A, 8'h00, 4'b1111, 5'b00000, 3'd0, 1'b0, 8'hFF, 1'b0, 8'h5A}, // R13 hold
        {4'd5,  8'h00, 8'h00, 4'b1110, 5'b11110, 3'd0, 1'b0, 8'h00, 1'b0, 8'h4B}  // R5 with R3 R4 R6
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [7:0] alu_res, mem_opnd, restore_word;
    logic alu_carry, alu_half, alu_ovf, shift_bit;
    logic upd_nz, upd_c, upd_h, upd_v, c_from_shift;
    logic [2:0] flag_cmd;
    logic bit_test, int_accept, restore_en;
    logic [7:0] psw;
    logic int_en, page_sel;
    logic [15:0] dp_base;
    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psw_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .alu_res(alu_res), .alu_carry(alu_carry),
        .alu_half(alu_half), .alu_ovf(alu_ovf), .shift_bit(shift_bit),
        .upd_nz(upd_nz), .upd_c(upd_c), .upd_h(upd_h), .upd_v(upd_v),
        .c_from_shift(c_from_shift), .flag_cmd(flag_cmd), .bit_test(bit_test),
        .mem_opnd(mem_opnd), .int_accept(int_accept), .restore_en(restore_en),
        .restore_word(restore_word), .psw(psw), .int_en(int_en),
        .page_sel(page_sel), .dp_base(dp_base)
    );

    task automatic idle();
        alu_res = 8'h00; alu_carry = 1'b0; alu_half = 1'b0; alu_ovf = 1'b0;
        shift_bit = 1'b0; upd_nz = 1'b0; upd_c = 1'b0; upd_h = 1'b0;
        upd_v = 1'b0; c_from_shift = 1'b0; flag_cmd = 3'd0; bit_test = 1'b0;
        mem_opnd = 8'h00; int_accept = 1'b0; restore_en = 1'b0;
        restore_word = 8'h00;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] w);
        idle();
        restore_en = 1'b1;
        restore_word = w;
        step();
        idle();
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        step();
        step();
        check("R1 word", {8'h00, psw}, 16'h0000);
        check("R1 side", {dp_base[14:0], int_en}, 16'h0000);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            logic [49:0] v;
            string tag;
            v = TBL[k];
            load(v[45:38]);
            alu_res = v[37:30];
            {alu_carry, alu_half, alu_ovf, shift_bit} = v[29:26];
            {upd_nz, upd_c, upd_h, upd_v, c_from_shift} = v[25:21];
            flag_cmd = v[20:18];
            bit_test = v[17];
            mem_opnd = v[16:9];
            int_accept = v[8];
            step();
            idle();
            tag = $sformatf("R%0d vec%0d", v[49:46], k);
            check(tag, {8'h00, psw}, {8'h00, v[7:0]});
            // R9 R11: dedicated outputs track the word
            check({tag, " side"}, {dp_base[14:0], int_en},
                  {(v[5] ? 15'h0100 : 15'h0000), v[2]});
        end

        // R2: restore beats every same-cycle update
        load(8'h00);
        restore_en = 1'b1; restore_word = 8'h3C;
        upd_nz = 1'b1; alu_res = 8'h00; upd_c = 1'b1; alu_carry = 1'b1;
        flag_cmd = 3'd2; bit_test = 1'b1; mem_opnd = 8'hFF; int_accept = 1'b1;
        step();
        idle();
        check("R2 priority", {8'h00, psw}, 16'h003C);
        check("R2 side", {14'h0, page_sel, int_en}, 16'h0003);

        // R12: break bit survives later updates and commands
        load(8'h00);
        flag_cmd = 3'd6;
        step();
        idle();
        upd_nz = 1'b1; upd_c = 1'b1; upd_h = 1'b1; upd_v = 1'b1; alu_carry = 1'b1;
        step();
        idle();
        flag_cmd = 3'd1;
        step();
        idle();
        flag_cmd = 3'd3; int_accept = 1'b1;
        step();
        idle();
        check("R12 hold", {8'h00, psw}, 16'h0013);

        // R1: reset in mid-run clears a full word
        load(8'hFF);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        check("R1 midrun", {8'h00, psw}, 16'h0000);
        check("R1 base", dp_base, 16'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule